// File: doc/BRIEF.md
# Triple-Mode Digital Phase Comparator

This block measures the phase relation between a reference input and a feedback input and presents the error in three forms at the same time. All three share one input stage and feed the loop filter of a phase-locked loop. The first form is the exclusive-OR of the two inputs. Its average duty encodes phase, and a loop built on it settles at a quarter-cycle offset. The second form is a rising-edge phase-frequency detector. It drives a charge-pump style output that can push up, push down, or float, and it has a quiet flag that stays high while no correction is applied. The third form is a set/reset sequential detector. The reference edge sets it and the feedback edge clears it, so its locked operating point is half a cycle.

Both inputs are asynchronous to the system clock. Each passes through a synchronizer and a rising-edge detector. The system clock must run at least eight times faster than the inputs. Every output is a registered digital pulse stream.

Top module: `phase_cmp_trio`

## Requirements
- R1: While `rst_n` is low at a clock edge, all outputs return to their idle values: `xor_out`, `pump_up`, `pump_dn`, `pump_oe` and `rs_out` are 0, and `lock_flag` is 1.
- R2: With the default two synchronizer stages, a change on an input first shows at the outputs after the third rising clock edge that follows it. It is not visible after the second.
- R3: `xor_out` equals the synchronized reference level XOR the synchronized feedback level.
- R4: From the idle state, a reference rising edge sets `pump_up`=1, and a feedback rising edge sets `pump_dn`=1.
- R5: A feedback edge while pushing up returns the detector to idle, and a reference edge while pushing down does the same. Repeated edges on the same input keep the current push. A reference running faster than the feedback therefore keeps `pump_up` on for most of the time and never asserts `pump_dn`.
- R6: When both inputs show a rising edge in the same clock cycle, neither the frequency detector nor the set/reset detector changes state.
- R7: `pump_up` and `pump_dn` are never 1 together. `pump_oe` is 1 exactly when one of them is 1; `pump_oe`=0 means the output floats.
- R8: `lock_flag` is 1 exactly when the frequency detector applies no correction.
- R9: A reference rising edge sets `rs_out` to 1. A feedback rising edge clears it to 0.
- R10: Falling edges and steady levels have no effect on the frequency detector or on `rs_out`.
- R11: With the reference held still and the feedback toggling, `pump_dn` stays on from the first feedback edge onward, and `rs_out` stays 0. Both steer the loop toward its lowest frequency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | 1 | Asynchronous reference (signal) input |
| fb_in | input | 1 | Asynchronous feedback (comparator) input |
| xor_out | output | 1 | Exclusive-OR detector output |
| pump_up | output | 1 | Frequency detector drive-high request |
| pump_dn | output | 1 | Frequency detector drive-low request |
| pump_oe | output | 1 | Frequency detector output enable (0 = float) |
| lock_flag | output | 1 | High while the frequency detector is idle |
| rs_out | output | 1 | Set/reset detector output |

## Verification
The hardest case to reach from the ports is two rising edges landing in the same sampling cycle. Only then does the frequency detector have to cancel the count. The bench gets there by driving both inputs high on the same falling clock edge. Identical synchronizers then deliver the two edges in the same cycle, and the bench checks that neither the pump state nor the set/reset output moves. Steady-state frequency behaviour comes from long periodic streams with a chosen period ratio, which are counted over whole beat periods.

// File: rtl/pcmp_pkg.sv
// Shared types for the triple-mode phase comparator.
package pcmp_pkg;

    // State of the edge-counting frequency detector.
    typedef enum logic [1:0] {
        PUMP_IDLE  = 2'b00,
        PUMP_RAISE = 2'b01,
        PUMP_LOWER = 2'b10
    } pump_state_t;

endpackage

// File: rtl/pcmp_edge_sync.sv
// Synchronizes one asynchronous input into the clk domain and flags its
// rising edges.
// Assumes: STAGES >= 2, and the input holds each level for several clk cycles.
// Outputs: the synchronized level, and a one-cycle pulse on each 0->1 change.
module pcmp_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise
);

    logic [STAGES-1:0] chain;
    logic              last;

    // First synchronizer flop samples the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= async_in;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            // Each later stage copies the previous one.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b0;
                else        chain[g] <= chain[g-1];
            end
        end
    endgenerate

    assign level = chain[STAGES-1];

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last <= 1'b0;
        else        last <= level;
    end

    assign rise = level & ~last;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R2

endmodule

// File: rtl/pcmp_freq_det.sv
// Rising-edge phase-frequency detector with a three-state pump output.
// Assumes: lead_rise and lag_rise are one-cycle pulses in the clk domain.
// Behaves as a saturating up/down counter over {lower, idle, raise}.
module pcmp_freq_det
    import pcmp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lead_rise,
    input  logic lag_rise,
    output logic pump_up,
    output logic pump_dn,
    output logic pump_oe,
    output logic quiet
);

    pump_state_t state_q, state_d;

    // Next-state: count up on lead, down on lag, saturate, ignore ties.
    always_comb begin
        state_d = state_q;
        if (lead_rise && !lag_rise) begin
            state_d = (state_q == PUMP_LOWER) ? PUMP_IDLE : PUMP_RAISE;
        end else if (lag_rise && !lead_rise) begin
            state_d = (state_q == PUMP_RAISE) ? PUMP_IDLE : PUMP_LOWER;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PUMP_IDLE;
        else        state_q <= state_d;
    end

    // Output decode from the registered state.
    always_comb begin
        pump_up = (state_q == PUMP_RAISE);
        pump_dn = (state_q == PUMP_LOWER);
        pump_oe = (state_q != PUMP_IDLE);
        quiet   = (state_q == PUMP_IDLE);
    end

    AST_PFD_TIE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (lead_rise && lag_rise) |=> $stable(state_q)); // R6
    AST_PFD_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (lead_rise && !lag_rise && state_q != PUMP_LOWER) |=> pump_up); // R4
    AST_PFD_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        (lag_rise && !lead_rise && state_q != PUMP_RAISE) |=> pump_dn); // R4
    AST_PFD_MEET: assert property (@(posedge clk) disable iff (!rst_n)
        (lead_rise && !lag_rise && state_q == PUMP_LOWER) |=> quiet); // R5
    AST_PFD_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!lead_rise && !lag_rise) |=> $stable(state_q)); // R10

endmodule

// File: rtl/pcmp_rs_det.sv
// Sequential set/reset phase detector.
// Assumes: set_rise and clr_rise are one-cycle pulses in the clk domain.
// Set wins on a lone set edge, clear on a lone clear edge; a tie holds.
module pcmp_rs_det (
    input  logic clk,
    input  logic rst_n,
    input  logic set_rise,
    input  logic clr_rise,
    output logic q
);

    // Output flop: set on reference edge, clear on feedback edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                    q <= 1'b0;
        else if (set_rise && !clr_rise) q <= 1'b1;
        else if (clr_rise && !set_rise) q <= 1'b0;
    end

    AST_RS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (set_rise && !clr_rise) |=> q); // R9
    AST_RS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rise && !set_rise) |=> !q); // R9
    AST_RS_TIE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (set_rise && clr_rise) |=> $stable(q)); // R6

endmodule

// File: rtl/phase_cmp_trio.sv
// Triple-mode phase comparator: XOR, edge phase-frequency and set/reset
// detectors running in parallel on one shared synchronizing input stage.
// Assumes: clk runs at least 8x the input frequencies; reset is synchronous.
module phase_cmp_trio #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic fb_in,
    output logic xor_out,
    output logic pump_up,
    output logic pump_dn,
    output logic pump_oe,
    output logic lock_flag,
    output logic rs_out
);

    localparam int NUM_IN = 2;
    localparam int IDX_REF = 0;
    localparam int IDX_FB  = 1;

    logic [NUM_IN-1:0] raw_in;
    logic [NUM_IN-1:0] lvl;
    logic [NUM_IN-1:0] rise;

    assign raw_in[IDX_REF] = ref_in;
    assign raw_in[IDX_FB]  = fb_in;

    genvar i;
    generate
        for (i = 0; i < NUM_IN; i++) begin : g_in
            pcmp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk      (clk),
                .rst_n    (rst_n),
                .async_in (raw_in[i]),
                .level    (lvl[i]),
                .rise     (rise[i])
            );
        end
    endgenerate

    // XOR detector, registered to line up with the edge-based detectors.
    always_ff @(posedge clk) begin
        if (!rst_n) xor_out <= 1'b0;
        else        xor_out <= lvl[IDX_REF] ^ lvl[IDX_FB];
    end

    pcmp_freq_det u_freq (
        .clk       (clk),
        .rst_n     (rst_n),
        .lead_rise (rise[IDX_REF]),
        .lag_rise  (rise[IDX_FB]),
        .pump_up   (pump_up),
        .pump_dn   (pump_dn),
        .pump_oe   (pump_oe),
        .quiet     (lock_flag)
    );

    pcmp_rs_det u_rs (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_rise (rise[IDX_REF]),
        .clr_rise (rise[IDX_FB]),
        .q        (rs_out)
    );

    AST_XOR_IDLE_ON_RESET: assert property (@(posedge clk)
        !rst_n |=> (!xor_out && !rs_out && lock_flag)); // R1

endmodule

// File: tb/phase_cmp_trio_bench.sv
module phase_cmp_trio_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_in = 1'b0;
    logic fb_in = 1'b0;
    logic xor_out, pump_up, pump_dn, pump_oe, lock_flag, rs_out;

    int vec_cnt = 0;
    int bad_cnt = 0;

    always #5 clk = ~clk;

    phase_cmp_trio u_phase_cmp_trio (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_in    (ref_in),
        .fb_in     (fb_in),
        .xor_out   (xor_out),
        .pump_up   (pump_up),
        .pump_dn   (pump_dn),
        .pump_oe   (pump_oe),
        .lock_flag (lock_flag),
        .rs_out    (rs_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vec_cnt++;
        if (act != exp) begin
            bad_cnt++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Check the four frequency-detector outputs together.
    task automatic chk_pump(input string tag, input int up, input int dn);
        chk({tag, " pump_up"}, pump_up, up);
        chk({tag, " pump_dn"}, pump_dn, dn);
        chk({tag, " pump_oe"}, pump_oe, (up | dn));
        chk({tag, " lock_flag"}, lock_flag, !(up | dn));
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ref_in = 1'b0; fb_in = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R1 xor_out", xor_out, 0);
        chk("R1 rs_out", rs_out, 0);
        chk_pump("R1", 0, 0);
    endtask

    task automatic t_xor_latency();
        do_reset();
        ref_in = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2 xor not yet", xor_out, 0);
        @(negedge clk);
        chk("R2 R3 xor ref only", xor_out, 1);
        fb_in = 1'b1;
        settle();
        chk("R3 xor both high", xor_out, 0);
        ref_in = 1'b0;
        settle();
        chk("R3 xor fb only", xor_out, 1);
    endtask

    task automatic t_pfd_basic();
        do_reset();
        ref_in = 1'b1; settle();
        chk_pump("R4 R7 R8 ref edge", 1, 0);
        fb_in = 1'b1; settle();
        chk_pump("R5 fb meets", 0, 0);
        fb_in = 1'b0; ref_in = 1'b0; settle();
        chk_pump("R10 falling edges", 0, 0);
        fb_in = 1'b1; settle();
        chk_pump("R4 fb edge", 0, 1);
        fb_in = 1'b0; settle();
        fb_in = 1'b1; settle();
        chk_pump("R5 fb saturate", 0, 1);
        ref_in = 1'b1; settle();
        chk_pump("R5 ref meets", 0, 0);
    endtask

    task automatic t_tie();
        do_reset();
        ref_in = 1'b1; settle();
        ref_in = 1'b0; settle();
        ref_in = 1'b1; fb_in = 1'b1; settle();
        chk_pump("R6 tie keeps raise", 1, 0);
        chk("R6 tie keeps rs set", rs_out, 1);
        ref_in = 1'b0; fb_in = 1'b0; settle();
        fb_in = 1'b1; settle();
        chk("R9 rs cleared", rs_out, 0);
        fb_in = 1'b0; settle();
        ref_in = 1'b1; fb_in = 1'b1; settle();
        chk("R6 tie keeps rs clear", rs_out, 0);
        chk_pump("R6 tie keeps idle", 0, 0);
    endtask

    task automatic t_rs();
        do_reset();
        ref_in = 1'b1; settle();
        chk("R9 rs set", rs_out, 1);
        ref_in = 1'b0; settle();
        chk("R10 rs ignores ref fall", rs_out, 1);
        fb_in = 1'b1; settle();
        chk("R9 rs clear", rs_out, 0);
        fb_in = 1'b0; settle();
        chk("R10 rs ignores fb fall", rs_out, 0);
    endtask

    task automatic t_no_ref();
        int dn_cnt = 0;
        int rs_cnt = 0;
        do_reset();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (i >= 8) begin
                if (pump_dn) dn_cnt++;
                if (rs_out)  rs_cnt++;
            end
            fb_in = ((i % 16) < 8);
        end
        chk("R11 pump_dn held", dn_cnt, 192);
        chk("R11 rs_out low", rs_cnt, 0);
    endtask

    task automatic t_fast_ref();
        int up_cnt = 0;
        int dn_cnt = 0;
        do_reset();
        for (int i = 0; i < 480; i++) begin
            ref_in = ((i % 16) < 8);
            fb_in  = (((i + 20) % 24) < 12);
            @(negedge clk);
            if (pump_up) up_cnt++;
            if (pump_dn) dn_cnt++;
        end
        chk("R5 fast ref up majority", (up_cnt * 2 > 480) ? 1 : 0, 1);
        chk("R5 fast ref no down", dn_cnt, 0);
    endtask

    initial begin
        t_reset_state();
        t_xor_latency();
        t_pfd_basic();
        t_tie();
        t_rs();
        t_no_ref();
        t_fast_ref();
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
        $finish;
    end

    initial begin
        #1_000_000;
        vec_cnt++;
        bad_cnt++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
        $finish;
    end

endmodule